// File: doc/BRIEF.md
# Key-Locked Configuration Register Slave

An eight-bit register slave for a simple system bus. It answers only inside a 256-byte window at a fixed base address. The window holds four identification bytes, a revision byte, a scratch byte, a 16-bit write-lock register, a sticky error byte, a soft-reset strobe and a protection control byte. The protection control byte chooses, for each of four transmit lanes, whether the working pair or the protect pair is routed.

Writes to the guarded registers take effect only while the lock holds the key value. A write that is refused leaves every register unchanged and raises a sticky error flag, which software clears explicitly. When the software-enable bit in the control byte is clear, each lane selection follows a dedicated external pin instead of the stored select bit. Read data is registered. The returned parity line is always low, and the parity that arrives with a write is ignored.

Top module: `cfg_lock_regs`

## Requirements
- R1: An access is decoded only when bus_addr[17:8] equals 0x300, so the window is base 0x30000 with 8 offset bits. Outside the window, writes change nothing and reads return 0x00.
- R2: Offsets 0x00 to 0x03 read the 32-bit ID parameter with its most significant byte at 0x00, and offset 0x04 reads the revision parameter. These bytes are read-only.
- R3: The lock register resets to 0x0000. Its high byte is at offset 0x06 and its low byte at 0x07, and both can be read and written whatever the lock state.
- R4: Writes to offsets 0x00 to 0x04, 0x08 and 0x0A are granted only while the lock holds exactly 0x0580. The scratch byte at 0x05 can always be written and reads back what was written.
- R5: A write to offset 0x00 to 0x04, 0x08 or 0x0A while the lock is not 0x0580 sets the error flag, which is bit 0 of offset 0x09. Such a write leaves every other register unchanged.
- R6: The error flag is sticky. Writing a value with bit 0 set to offset 0x09 clears it, whatever the lock state.
- R7: A granted write with bit 0 set to offset 0x0A returns the lock, the control byte and the error flag to zero on that clock edge, and it leaves the scratch byte unchanged. Offset 0x0A always reads 0x00.
- R8: Offset 0x08 is the control byte. Bit 7 is the software enable and bits 3:0 are the lane selects. It resets to 0x00, and bits 6:4 always read 0.
- R9: lane_prot[i] is select bit i when bit 7 of offset 0x08 is 1, and lane_sel_pin[i] when it is 0. A value of 0 routes the working pair and 1 routes the protect pair.
- R10: A read strobe sampled at a clock edge places the addressed byte on bus_rdata after that edge. bus_rpar is always 0, and bus_wpar has no effect.
- R11: Offsets inside the window that are not listed above read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 18 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Write parity (ignored) |
| bus_rdata | output | 8 | Registered read data |
| bus_rpar | output | 1 | Read parity, always 0 |
| lane_sel_pin | input | 4 | External per-lane protect selects |
| lane_prot | output | 4 | Per-lane route: 0 working, 1 protect |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
The assertions assume that at most one of bus_wr and bus_rd is high in any cycle, and that strobes and data are stable around the clock edge. The bench drives a single strobe per transaction on the falling edge and never raises both strobes together. Random traffic mixes addresses inside and outside the window, random parity, lock bytes that only sometimes form the key, and random lane pins. This exercises both granted and refused guarded writes against a reference model in the bench.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
   localparam int OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_ID0  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_ID3  = 8'h03;
   localparam logic [OFS_W-1:0] OFS_REV  = 8'h04;
   localparam logic [OFS_W-1:0] OFS_SCR  = 8'h05;
   localparam logic [OFS_W-1:0] OFS_LKH  = 8'h06;
   localparam logic [OFS_W-1:0] OFS_LKL  = 8'h07;
   localparam logic [OFS_W-1:0] OFS_PROT = 8'h08;
   localparam logic [OFS_W-1:0] OFS_ERR  = 8'h09;
   localparam logic [OFS_W-1:0] OFS_SRST = 8'h0A;
   localparam logic [15:0]      LOCK_KEY = 16'h0580;

   function automatic logic is_guarded(input logic [OFS_W-1:0] ofs);
      return (ofs <= OFS_REV) || (ofs == OFS_PROT) || (ofs == OFS_SRST);
   endfunction
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
   parameter int          ADDR_W = 18,
   parameter int          OFS_W  = 8,
   parameter logic [31:0] BASE   = 32'h30000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [OFS_W-1:0]  ofs
);
   localparam int HI_W = ADDR_W - OFS_W;
   localparam logic [HI_W-1:0] BASE_HI = BASE[ADDR_W-1:OFS_W];

   initial begin
      if (ADDR_W <= OFS_W) $error("ADDR_W must exceed OFS_W");
      if (BASE[OFS_W-1:0] != '0) $error("BASE must be window aligned");
   end

   assign hit = (addr[ADDR_W-1:OFS_W] == BASE_HI);
   assign ofs = addr[OFS_W-1:0];
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate
   import cfg_lock_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [OFS_W-1:0] ofs,
   input  logic [DW-1:0]    wdata,
   output logic [15:0]      lock_q,
   output logic             err_q,
   output logic             grant,
   output logic             srst
);
   logic perm, guarded, refuse, err_clr;

   initial if (DW != 8) $error("gate expects an 8-bit data path");

   assign perm    = (lock_q == LOCK_KEY);
   assign guarded = is_guarded(ofs);
   assign grant   = wr_hit && guarded && perm;
   assign refuse  = wr_hit && guarded && !perm;
   assign srst    = grant && (ofs == OFS_SRST) && wdata[0];
   assign err_clr = wr_hit && (ofs == OFS_ERR) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         lock_q <= '0;
      end else if (wr_hit && ofs == OFS_LKH) begin
         lock_q[15:8] <= wdata;
      end else if (wr_hit && ofs == OFS_LKL) begin
         lock_q[7:0] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst)   err_q <= 1'b0;
      else if (refuse)      err_q <= 1'b1;
      else if (err_clr)     err_q <= 1'b0;
   end

   a_r5_refused_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && guarded && lock_q != LOCK_KEY) |=> err_q);
   a_r5_refused_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && guarded && lock_q != LOCK_KEY) |=> $stable(lock_q));
   a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && ofs == OFS_ERR && wdata[0]) |=> !err_q);
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !wr_hit) |=> err_q);
   a_r7_srst_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (lock_q == 16'h0000 && !err_q));
endmodule

// File: rtl/cfg_lock_protsel.sv
module cfg_lock_protsel #(
   parameter int NCH    = 4,
   parameter int DW     = 8,
   parameter int EN_BIT = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           srst,
   input  logic           ctrl_we,
   input  logic [DW-1:0]  wdata,
   input  logic [NCH-1:0] sel_pin,
   output logic [DW-1:0]  ctrl_q,
   output logic [NCH-1:0] lane_prot
);
   localparam logic [DW-1:0] KEEP_MASK = DW'((1 << NCH) - 1) | DW'(1 << EN_BIT);

   initial begin
      if (NCH < 1 || NCH >= EN_BIT) $error("NCH must lie below EN_BIT");
      if (EN_BIT >= DW) $error("EN_BIT outside data path");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst) ctrl_q <= '0;
      else if (ctrl_we)   ctrl_q <= wdata & KEEP_MASK;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      always_comb begin
         if (ctrl_q[EN_BIT]) lane_prot[i] = ctrl_q[i];
         else                lane_prot[i] = sel_pin[i];
      end
   end

   a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> ((ctrl_q & ~KEEP_MASK) == '0));
   a_r7_srst_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctrl_q == '0));
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
   import cfg_lock_pkg::*;
#(
   parameter int          ADDR_W = 18,
   parameter logic [31:0] BASE   = 32'h30000,
   parameter int          NCH    = 4,
   parameter logic [31:0] DEV_ID = 32'hA5C3_1E07,
   parameter logic [7:0]  REV    = 8'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wpar,
   output logic [7:0]        bus_rdata,
   output logic              bus_rpar,
   input  logic [NCH-1:0]    lane_sel_pin,
   output logic [NCH-1:0]    lane_prot,
   output logic              wr_err
);
   localparam int DW = 8;

   logic             hit, wr_hit, grant, srst, err_q;
   logic [OFS_W-1:0] ofs;
   logic [15:0]      lock_q;
   logic [DW-1:0]    ctrl_q, scratch_q, rd_mux;
   logic             unused_par;

   assign unused_par = bus_wpar;

   cfg_lock_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE(BASE)) u_dec (
      .addr(bus_addr), .hit(hit), .ofs(ofs));

   assign wr_hit = bus_wr && hit;

   cfg_lock_gate #(.DW(DW)) u_gate (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .ofs(ofs), .wdata(bus_wdata),
      .lock_q(lock_q), .err_q(err_q), .grant(grant), .srst(srst));

   cfg_lock_protsel #(.NCH(NCH), .DW(DW), .EN_BIT(7)) u_prot (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .ctrl_we(grant && ofs == OFS_PROT), .wdata(bus_wdata),
      .sel_pin(lane_sel_pin), .ctrl_q(ctrl_q), .lane_prot(lane_prot));

   always_ff @(posedge clk) begin
      if (!rst_n)                       scratch_q <= '0;
      else if (wr_hit && ofs == OFS_SCR) scratch_q <= bus_wdata;
   end

   always_comb begin
      case (ofs)
         8'h00:    rd_mux = DEV_ID[31:24];
         8'h01:    rd_mux = DEV_ID[23:16];
         8'h02:    rd_mux = DEV_ID[15:8];
         OFS_ID3:  rd_mux = DEV_ID[7:0];
         OFS_REV:  rd_mux = REV;
         OFS_SCR:  rd_mux = scratch_q;
         OFS_LKH:  rd_mux = lock_q[15:8];
         OFS_LKL:  rd_mux = lock_q[7:0];
         OFS_PROT: rd_mux = ctrl_q;
         OFS_ERR:  rd_mux = {7'b0, err_q};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= hit ? rd_mux : '0;
   end

   assign bus_rpar = 1'b0;
   assign wr_err   = err_q;

   a_r11_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> (bus_rdata == 8'h00));
   a_r4_scratch_free: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && ofs == OFS_SCR) |=> (scratch_q == $past(bus_wdata)));
   a_r5_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && ofs == OFS_PROT && lock_q != LOCK_KEY) |=> $stable(ctrl_q));
   a_r7_srst_keeps_scratch: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> $stable(scratch_q));
   a_r1_outside_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> ($stable(lock_q) && $stable(ctrl_q) && $stable(scratch_q)));
endmodule

// File: tb/cfg_lock_regs_bench.sv
module cfg_lock_regs_bench;
   localparam logic [31:0] ID_EXP  = 32'hA5C3_1E07;
   localparam logic [7:0]  REV_EXP = 8'h12;
   localparam logic [17:0] WIN     = 18'h30000;

   logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, bus_wpar = 0, wr_err;
   logic [17:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0, bus_rdata;
   logic        bus_rpar;
   logic [3:0]  lane_sel_pin = '0, lane_prot;

   int checks = 0, errors = 0;
   bit finished = 0;

   logic [15:0] m_lock;
   logic [7:0]  m_ctrl, m_scr;
   logic        m_err;

   always #10 clk = ~clk;

   cfg_lock_regs u_cfg_lock_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_wpar(bus_wpar), .bus_rdata(bus_rdata), .bus_rpar(bus_rpar),
      .lane_sel_pin(lane_sel_pin), .lane_prot(lane_prot), .wr_err(wr_err));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [17:0] a);
      if (a[17:8] != WIN[17:8]) return 8'h00;
      case (a[7:0])
         8'h00: return ID_EXP[31:24];
         8'h01: return ID_EXP[23:16];
         8'h02: return ID_EXP[15:8];
         8'h03: return ID_EXP[7:0];
         8'h04: return REV_EXP;
         8'h05: return m_scr;
         8'h06: return m_lock[15:8];
         8'h07: return m_lock[7:0];
         8'h08: return m_ctrl;
         8'h09: return {7'b0, m_err};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [3:0] exp_lanes(input logic [3:0] pins);
      return m_ctrl[7] ? m_ctrl[3:0] : pins;
   endfunction

   task automatic model_wr(input logic [17:0] a, input logic [7:0] d);
      logic [7:0] o;
      o = a[7:0];
      if (a[17:8] != WIN[17:8]) return;
      if (o == 8'h05) m_scr = d;
      else if (o == 8'h06) m_lock[15:8] = d;
      else if (o == 8'h07) m_lock[7:0] = d;
      else if (o == 8'h09) begin if (d[0]) m_err = 0; end
      else if (o <= 8'h04 || o == 8'h08 || o == 8'h0A) begin
         if (m_lock == 16'h0580) begin
            if (o == 8'h08) m_ctrl = d & 8'h8F;
            if (o == 8'h0A && d[0]) begin m_lock = 0; m_ctrl = 0; m_err = 0; end
         end else m_err = 1;
      end
   endtask

   task automatic do_wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wpar = 1'($urandom);
      @(negedge clk);
      bus_wr = 0;
      model_wr(a, d);
   endtask

   task automatic do_rd(input logic [17:0] a, input string tag);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      chk(tag, bus_rdata, exp_read(a));
      chk("R10 rpar", bus_rpar, 0);
   endtask

   task automatic chk_lanes(input string tag);
      lane_sel_pin = 4'($urandom);
      #1;
      chk(tag, lane_prot, exp_lanes(lane_sel_pin));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_lock = 0; m_ctrl = 0; m_scr = 0; m_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state
      chk("R3 reset wr_err", wr_err, 0);
      do_rd(WIN | 18'h06, "R3 lock high reset");
      do_rd(WIN | 18'h07, "R3 lock low reset");
      do_rd(WIN | 18'h08, "R8 ctrl reset");
      for (int i = 0; i < 5; i++) do_rd(WIN | 18'(i), "R2 id/rev");
      chk_lanes("R9 pins follow at reset");
      // locked guarded write refused
      do_wr(WIN | 18'h08, 8'h8F);
      do_rd(WIN | 18'h08, "R5 ctrl unchanged when locked");
      chk("R5 error set", wr_err, 1);
      do_wr(WIN | 18'h09, 8'h00);
      chk("R6 error sticky on zero write", wr_err, 1);
      do_wr(WIN | 18'h09, 8'h01);
      chk("R6 error cleared while locked", wr_err, 0);
      do_wr(WIN | 18'h05, 8'h3C);
      do_rd(WIN | 18'h05, "R4 scratch writable while locked");
      chk("R4 scratch no error", wr_err, 0);
      // unlock with key
      do_wr(WIN | 18'h06, 8'h05);
      do_wr(WIN | 18'h07, 8'h80);
      do_rd(WIN | 18'h06, "R3 lock high readback");
      do_wr(WIN | 18'h08, 8'hFF);
      do_rd(WIN | 18'h08, "R8 unused ctrl bits read zero");
      chk_lanes("R9 software select");
      do_wr(WIN | 18'h02, 8'h00);
      do_rd(WIN | 18'h02, "R2 id read-only");
      chk("R4 unlocked guarded write no error", wr_err, 0);
      do_wr(WIN | 18'h08, 8'h05);
      chk_lanes("R9 pins when enable clear");
      // outside window and unmapped
      do_wr(18'h20005, 8'hEE);
      do_rd(WIN | 18'h05, "R1 outside write ignored");
      do_rd(18'h20005, "R1 outside read zero");
      do_wr(WIN | 18'h33, 8'h77);
      do_rd(WIN | 18'h33, "R11 unmapped reads zero");
      // soft reset
      do_wr(WIN | 18'h08, 8'h83);
      do_wr(WIN | 18'h0A, 8'h01);
      do_rd(WIN | 18'h07, "R7 lock cleared");
      do_rd(WIN | 18'h08, "R7 ctrl cleared");
      do_rd(WIN | 18'h05, "R7 scratch kept");
      do_rd(WIN | 18'h0A, "R7 srst reads zero");
      do_wr(WIN | 18'h0A, 8'h01);
      chk("R7 relocked after soft reset", wr_err, 1);
      // random traffic
      for (int n = 0; n < 600; n++) begin
         int k;
         logic [17:0] a;
         logic [7:0]  d;
         k = $urandom_range(0, 9);
         a = ($urandom_range(0, 7) == 0) ? 18'($urandom) : (WIN | 18'($urandom_range(0, 12)));
         d = 8'($urandom);
         if (k == 0) begin
            do_wr(WIN | 18'h06, 8'h05);
            do_wr(WIN | 18'h07, ($urandom_range(0, 3) == 0) ? 8'h81 : 8'h80);
         end else if (k < 5) begin
            if (a[7:0] == 8'h0A && $urandom_range(0, 3) != 0) d[0] = 0;
            do_wr(a, d);
         end else do_rd(a, "R4 random readback");
         chk("R5 random error flag", wr_err, m_err);
         chk_lanes("R9 random lanes");
      end
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule